// File: doc/BRIEF.md
# Command-Port Buffer Access Sequencer

This block sits between a host microprocessor bus and a single-port packet buffer RAM. The processor never addresses the RAM directly. It opens an access cycle by writing a command code to a command port, and then it streams 16-bit words through a data port. The sequencer supplies the RAM address itself. The address starts at word 0 for each new cycle and advances by one word on every data-port strobe.

A programmable byte count bounds each access cycle. The sequencer turns the byte count into a word count, rounding up, and locks the cycle to one direction: either buffer write or buffer read. A data-port access in the wrong direction, or one that arrives after the word count is used up, leaves the RAM untouched and sets a sticky error flag. When the last word has moved, the sequencer pulses a done flag and goes back to idle.

For reads, the sequencer prefetches the next word from the synchronous RAM. This lets the processor take each word directly on its read strobe.

Top module: `bufseq_top`

## Requirements
- R1: A command-port write whose bits 7:0 equal 0xA2, followed by a data-port write, loads the byte count from that data word. A command-port write with bits 7:0 equal 0x22, followed by a data-port read, returns the byte count on `bus_rdata`.
- R2: Command code 0xC0 opens a buffer write cycle. Each data-port write stores `bus_wdata` into the RAM at consecutive word addresses, starting at 0, in the same cycle as the strobe.
- R3: Command code 0x40 opens a buffer read cycle. Successive data-port reads return the RAM words at addresses 0, 1, 2 and so on. Strobes must be at least 4 clocks apart, and the first strobe must also be at least 4 clocks after the command.
- R4: A cycle moves ceil(byte_count/2) words, so an odd byte count is rounded up to a whole word.
- R5: `seq_done` is high for exactly the one clock that follows the data strobe which moves the final word. A buffer command given while the byte count is 0 produces the same pulse in the clock after the command.
- R6: A data-port access in the direction opposite to the open phase does not write the RAM and sets `seq_err`. The open cycle continues with its address and remaining count unchanged. This applies to a read during a write cycle, a write during a read cycle, and the opposite access in either count phase.
- R7: A data-port access while no cycle is open, including after the word count is exhausted, does not write the RAM and sets `seq_err`.
- R8: A new buffer command, even one given in the middle of a cycle, restarts the address at 0 and reloads the word count.
- R9: After reset, `seq_done` and `seq_err` are 0, `ram_en` is 0 and the byte count is 0.
- R10: `seq_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select; qualifies each strobe |
| bus_a | input | 1 | Port select: 1 selects the command port, 0 selects the data port |
| bus_rd | input | 1 | Read strobe; one access for each clock it is high |
| bus_wr | input | 1 | Write strobe; one access for each clock it is high |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_rdata | output | DATA_W | Read data to the processor |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, valid one clock after a read |
| seq_done | output | 1 | One-clock pulse at the end of an access cycle |
| seq_err | output | 1 | Sticky error flag for an illegal data access |

## Verification
The main function is exercised with three kinds of stimulus. Full even-count write and read cycles show that addresses advance in order and that the data round-trips. An odd count shows that the word count is rounded up and that the first excess access is rejected. A command reissued in the middle of a cycle shows that the address restarts. Wrong-direction strobes inside an open cycle are told apart from strobes after the count runs out: in the first case the next legal words still land at the following addresses. A zero byte count separates an immediate done pulse from a cycle that never opens.

// File: rtl/bufseq_pkg.sv
package bufseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CNT_WR = 3'd1,
    PH_CNT_RD = 3'd2,
    PH_BUF_WR = 3'd3,
    PH_BUF_RD = 3'd4
  } phase_e;

  localparam int          CODE_W     = 8;
  localparam logic [7:0]  CMD_CNT_RD = 8'h22;
  localparam logic [7:0]  CMD_CNT_WR = 8'hA2;
  localparam logic [7:0]  CMD_BUF_RD = 8'h40;
  localparam logic [7:0]  CMD_BUF_WR = 8'hC0;

endpackage

// File: rtl/bufseq_rst_sync.sv
module bufseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] shift_q;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n_sync = shift_q[1];

endmodule

// File: rtl/bufseq_cmd_dec.sv
module bufseq_cmd_dec
  import bufseq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output phase_e            ph,
  output logic              is_buf,
  output logic              is_rd
);

  always_comb begin
    case (code)
      CMD_CNT_WR: ph = PH_CNT_WR;
      CMD_CNT_RD: ph = PH_CNT_RD;
      CMD_BUF_WR: ph = PH_BUF_WR;
      CMD_BUF_RD: ph = PH_BUF_RD;
      default:    ph = PH_IDLE;
    endcase
  end

  assign is_buf = (ph == PH_BUF_WR) || (ph == PH_BUF_RD);
  assign is_rd  = (ph == PH_BUF_RD);

endmodule

// File: rtl/bufseq_wcount.sv
module bufseq_wcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_bytes,
  input  logic [CNT_W-1:0] bytes_in,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] bytes_q,
  output logic             words_zero,
  output logic             remain_last
);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] total_words;
  logic [CNT_W-1:0] remain_q, remain_n;
  logic             remain_en;

  // round an odd byte count up to a whole word
  assign sum         = {1'b0, bytes_q} + {{CNT_W{1'b0}}, 1'b1};
  assign total_words = sum[CNT_W:1];
  assign words_zero  = (total_words == '0);
  assign remain_last = (remain_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_comb begin
    remain_en = start | step;
    if (start) remain_n = total_words;
    else       remain_n = remain_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bytes_q <= '0;
    else if (ld_bytes) bytes_q <= bytes_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_n;
  end

endmodule

// File: rtl/bufseq_ramport.sv
module bufseq_ramport #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              step_wr,
  input  logic              step_rd,
  input  logic              last,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] hold
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic              ptr_en;
  logic              rd_issue;
  logic              pend_q;

  assign ptr_inc = ptr_q + ADDR_ONE;

  // prefetch: word 0 at command time, the next word after each read strobe
  assign rd_issue  = (start & start_rd) | (step_rd & ~last);
  assign ram_we    = step_wr;
  assign ram_en    = step_wr | rd_issue;
  assign ram_wdata = wdata;

  always_comb begin
    if (step_wr)    ram_addr = ptr_q;
    else if (start) ram_addr = '0;
    else            ram_addr = ptr_inc;
  end

  always_comb begin
    ptr_en = start | step_wr | step_rd;
    if (start) ptr_n = '0;
    else       ptr_n = ptr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= rd_issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold <= '0;
    else if (pend_q) hold <= ram_rdata;
  end

endmodule

// File: rtl/bufseq_top.sv
module bufseq_top
  import bufseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_a,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              seq_done,
  output logic              seq_err
);

  logic              rst_n_s;
  logic              acc_wr, acc_rd, cmd_wr, dat_wr, dat_rd;
  phase_e            phase_q, phase_n, dec_ph;
  logic              dec_buf, dec_rd;
  logic              err_n, done_n;
  logic              start, step_wr, step_rd, ld_bytes;
  logic [CNT_W-1:0]  bytes_q;
  logic              words_zero, remain_last;
  logic [DATA_W-1:0] hold;

  bufseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // one access per strobe clock; both strobes together are ignored
  assign acc_wr = bus_cs & bus_wr & ~bus_rd;
  assign acc_rd = bus_cs & bus_rd & ~bus_wr;
  assign cmd_wr = acc_wr &  bus_a;
  assign dat_wr = acc_wr & ~bus_a;
  assign dat_rd = acc_rd & ~bus_a;

  bufseq_cmd_dec u_dec (
    .code   (bus_wdata[CODE_W-1:0]),
    .ph     (dec_ph),
    .is_buf (dec_buf),
    .is_rd  (dec_rd)
  );

  always_comb begin
    phase_n  = phase_q;
    err_n    = seq_err;
    done_n   = 1'b0;
    start    = 1'b0;
    step_wr  = 1'b0;
    step_rd  = 1'b0;
    ld_bytes = 1'b0;
    if (cmd_wr) begin
      if (dec_buf && words_zero) begin
        phase_n = PH_IDLE;
        done_n  = 1'b1;
      end else begin
        phase_n = dec_ph;
        start   = dec_buf;
      end
    end else if (dat_wr) begin
      case (phase_q)
        PH_CNT_WR: begin
          ld_bytes = 1'b1;
          phase_n  = PH_IDLE;
        end
        PH_BUF_WR: begin
          step_wr = 1'b1;
          if (remain_last) begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end
        end
        default: err_n = 1'b1;
      endcase
    end else if (dat_rd) begin
      case (phase_q)
        PH_CNT_RD: phase_n = PH_IDLE;
        PH_BUF_RD: begin
          step_rd = 1'b1;
          if (remain_last) begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end
        end
        default: err_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q  <= PH_IDLE;
      seq_err  <= 1'b0;
      seq_done <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      seq_err  <= err_n;
      seq_done <= done_n;
    end
  end

  bufseq_wcount #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ld_bytes    (ld_bytes),
    .bytes_in    (CNT_W'(bus_wdata)),
    .start       (start),
    .step        (step_wr | step_rd),
    .bytes_q     (bytes_q),
    .words_zero  (words_zero),
    .remain_last (remain_last)
  );

  bufseq_ramport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .start_rd  (dec_rd),
    .step_wr   (step_wr),
    .step_rd   (step_rd),
    .last      (remain_last),
    .wdata     (bus_wdata),
    .ram_rdata (ram_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .hold      (hold)
  );

  assign bus_rdata = (phase_q == PH_CNT_RD) ? DATA_W'(bytes_q) : hold;

endmodule

// File: rtl/bufseq_chk.sv
module bufseq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_a,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              seq_done,
  input logic              seq_err
);

  AST_RAM_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (bus_cs && bus_wr && !bus_rd && !bus_a)); // R2

  AST_RAM_WDATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata == bus_wdata)); // R2

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(bus_cs && (bus_wr || bus_rd))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R10

  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !$past(ram_we)); // R6

endmodule

bind bufseq_top bufseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_a     (bus_a),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata),
  .seq_done  (seq_done),
  .seq_err   (seq_err)
);

// File: tb/sim_bufseq_top.sv
`timescale 1ns/1ps
module sim_bufseq_top;

  localparam int DW = 16;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_cs, bus_a, bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          seq_done, seq_err;

  logic [DW-1:0] mem [1 << AW];

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic          got_done;
  logic [DW-1:0] got_data;

  always #2 clk = ~clk;

  bufseq_top #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_a(bus_a),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  // single-port synchronous RAM model, one clock read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_cs = 0; bus_a = 0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_cs = 1; bus_a = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
    got_done = seq_done;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read();
    @(negedge clk);
    bus_cs = 1; bus_a = 0; bus_rd = 1;
    #1 got_data = bus_rdata;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
    got_done = seq_done;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_count(input logic [DW-1:0] n);
    bus_write(1'b1, 16'h00A2);
    bus_write(1'b0, n);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 done", seq_done, 0);
    chk("R9 err", seq_err, 0);
    chk("R9 ram_en", ram_en, 0);
    bus_write(1'b1, 16'h0022);
    bus_read();
    chk("R9 count", got_data, 16'h0000);
  endtask

  task automatic t_count();
    set_count(16'h0008);
    bus_write(1'b1, 16'hFF22);
    bus_read();
    chk("R1 count readback", got_data, 16'h0008);
    chk("R1 no err", seq_err, 0);
  endtask

  task automatic t_write();
    bus_write(1'b1, 16'h00C0);
    for (int i = 0; i < 4; i++) begin
      bus_write(1'b0, 16'hA000 + 16'(i));
      chk("R5 done per word", got_done, (i == 3));
    end
    for (int i = 0; i < 4; i++) chk("R2 ram word", mem[i], 16'hA000 + 16'(i));
    chk("R2 no err", seq_err, 0);
  endtask

  task automatic t_read();
    bus_write(1'b1, 16'h0040);
    for (int i = 0; i < 4; i++) begin
      bus_read();
      chk("R3 read word", got_data, 16'hA000 + 16'(i));
      chk("R5 done on read", got_done, (i == 3));
    end
  endtask

  task automatic t_odd();
    set_count(16'h0005);
    bus_write(1'b1, 16'h00C0);
    for (int i = 0; i < 3; i++) begin
      bus_write(1'b0, 16'hB100 + 16'(i));
      chk("R4 done at third", got_done, (i == 2));
    end
    for (int i = 0; i < 3; i++) chk("R4 ram word", mem[i], 16'hB100 + 16'(i));
    chk("R4 no err yet", seq_err, 0);
    bus_write(1'b0, 16'hDEAD);
    chk("R7 err after exhaust", seq_err, 1);
    chk("R7 ram untouched", mem[3], 16'hA003);
    repeat (10) @(negedge clk);
    chk("R10 err sticky", seq_err, 1);
    bus_write(1'b1, 16'h00C0);
    chk("R10 err held over command", seq_err, 1);
  endtask

  task automatic t_dir();
    do_reset();
    set_count(16'h0006);
    bus_write(1'b1, 16'h00C0);
    bus_write(1'b0, 16'hC500);
    bus_read();
    chk("R6 err on wrong dir", seq_err, 1);
    chk("R6 done not pulsed", got_done, 0);
    chk("R6 ram untouched", mem[1], 16'hB101);
    bus_write(1'b0, 16'hC501);
    chk("R6 cycle continues", got_done, 0);
    bus_write(1'b0, 16'hC502);
    chk("R6 done after third", got_done, 1);
    chk("R6 word1", mem[1], 16'hC501);
    chk("R6 word2", mem[2], 16'hC502);
  endtask

  task automatic t_restart();
    do_reset();
    set_count(16'h0008);
    bus_write(1'b1, 16'h00C0);
    bus_write(1'b0, 16'hD100);
    bus_write(1'b0, 16'hD101);
    bus_write(1'b1, 16'h00C0);
    bus_write(1'b0, 16'hD200);
    chk("R8 restart addr0", mem[0], 16'hD200);
    chk("R8 word1 kept", mem[1], 16'hD101);
    chk("R8 no err", seq_err, 0);
    bus_write(1'b1, 16'h0040);
    bus_read();
    chk("R8 read restarts", got_data, 16'hD200);
    bus_read();
    chk("R3 second read", got_data, 16'hD101);
  endtask

  task automatic t_zero();
    do_reset();
    bus_write(1'b1, 16'h00C0);
    chk("R5 zero count done", got_done, 1);
    @(negedge clk);
    chk("R5 done one clock", seq_done, 0);
    bus_write(1'b0, 16'hEEEE);
    chk("R7 err in idle", seq_err, 1);
    chk("R7 ram untouched idle", mem[0], 16'hD200);
  endtask

  initial begin
    t_reset();
    t_count();
    t_write();
    t_read();
    t_odd();
    t_dir();
    t_restart();
    t_zero();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule